// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This is a single-cycle-latency bit-field execution unit for a 32-bit processor datapath. One operation code picks among four functions: a funnel-shift extraction from a double-width word made of two operands, a field extraction with sign extension, a field extraction with zero extension, and a field insertion. The bit position and the field width come from two separate 32-bit operands, as if read from an even/odd register pair. Only the low five bits of each are used.

The caller presents the operands together with a one-cycle `start` strobe. On that clock edge the unit captures the computed value into its result register. The following cycle it shows the value on `result`, with `done` high. The control is a two-state machine. `ST_IDLE` moves to `ST_RESULT` when `start` is high (transition "launch"). `ST_RESULT` stays in `ST_RESULT` when another `start` arrives (transition "chain"). `ST_RESULT` returns to `ST_IDLE` when `start` is low (transition "retire"). `ST_IDLE` stays in `ST_IDLE` when `start` is low (transition "wait"). `done` is high exactly in `ST_RESULT`.

Top module: `bitfield_unit`

## Requirements
- R1: The operation code `op` selects the function. 0 is double extract, 1 is signed extract, 2 is unsigned extract, and 3 is insert.
- R2: The bit position is `pos_in[4:0]`. Bits 31:5 of `pos_in` have no effect on the result.
- R3: The field width is `wid_in[4:0]`. Bits 31:5 of `wid_in` have no effect on the result.
- R4: Double extract returns bits 63:32 of the 64-bit word {`opa`,`opb`} shifted left by the position. A position of 0 returns `opa` unchanged.
- R5: When `opb` equals `opa`, double extract returns `opa` rotated left by the position.
- R6: Signed extract returns `opa` bits [pos+width-1:pos] in the low bits of the result, sign-extended from the top bit of the field. A width of 0 returns 0.
- R7: Unsigned extract returns the same field zero-extended. A width of 0 returns 0.
- R8: When pos+width exceeds 32, the field ends at bit 31. An extract then returns `opa` bits 31 down to pos, extended from bit 31 (sign-extended for signed extract, zero-extended for unsigned extract).
- R9: Insert returns `opa` with bits [pos+width-1:pos] replaced by the low width bits of `opb`. Field bits above bit 31 are discarded, and all other bits of `opa` are kept.
- R10: Insert with a width of 0 returns `opa` unchanged.
- R11: `result` and `done` change one clock after a cycle with `start` high, and `done` is then high. After a cycle with `start` low, `done` is low and `result` holds its value.
- R12: A synchronous active-high `rst` clears `result` to 0 and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Strobe that captures an operation |
| op | input | 2 | Operation code (0 double extract, 1 signed extract, 2 unsigned extract, 3 insert) |
| opa | input | 32 | First data operand (upper word / insert target) |
| opb | input | 32 | Second data operand (lower word / insert source) |
| pos_in | input | 32 | Position operand, low 5 bits used |
| wid_in | input | 32 | Width operand, low 5 bits used |
| result | output | 32 | Registered result |
| done | output | 1 | High the cycle after a start |

## Verification
The hardest cases to reach from the ports are fields that cross bit 31 and the zero edges: position 0, where the funnel must not depend on a full-width right shift, and width 0. Random operands rarely land on these exact combinations. The stimulus therefore steers the low five bits of position and width to those values on purpose, with arbitrary junk in the upper bits. The stimulus also sends back-to-back strobes with no idle gap, so the chain transition and the retire transition are both exercised.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        OP_DEXT = 2'd0,
        OP_SEXT = 2'd1,
        OP_UEXT = 2'd2,
        OP_INS  = 2'd3
    } bf_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } bf_state_e;
endpackage

// File: rtl/bfu_funnel.sv
module bfu_funnel #(
    parameter int DW = 32,
    localparam int PW = $clog2(DW)
) (
    input  logic [DW-1:0] hi,
    input  logic [DW-1:0] lo,
    input  logic [PW-1:0] sh,
    output logic [DW-1:0] y
);
    logic [2*DW-1:0] joined;

    // Left shift of the double word; the upper half is the window.
    // Shift 0 yields hi directly, with no full-width right shift.
    always_comb begin
        joined = {hi, lo} << sh;
        y      = joined[2*DW-1:DW];
    end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
    parameter int DW = 32,
    localparam int PW = $clog2(DW),
    localparam int EW = PW + 1
) (
    input  logic [DW-1:0] a,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] wid,
    input  logic          sign_ext,
    output logic [DW-1:0] y
);
    logic [EW-1:0] room;
    logic [EW-1:0] eff;
    logic [DW-1:0] shifted;
    logic [DW-1:0] keep;
    logic [PW-1:0] top_idx;
    logic          fill;

    always_comb begin
        room    = EW'(DW) - EW'(pos);
        eff     = (EW'(wid) > room) ? room : EW'(wid);
        shifted = a >> pos;
        keep    = ~({DW{1'b1}} << eff);
        top_idx = PW'(eff - EW'(1));
        fill    = sign_ext && (eff != '0) && shifted[top_idx];
        y       = (shifted & keep) | (fill ? ~keep : '0);
    end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
    parameter int DW = 32,
    localparam int PW = $clog2(DW)
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic [PW-1:0] pos,
    input  logic [PW-1:0] wid,
    output logic [DW-1:0] y
);
    logic [DW-1:0] field_mask;

    // Bits pushed past the top by the position shift are lost,
    // which truncates the field at the most significant bit.
    always_comb begin
        field_mask = (~({DW{1'b1}} << wid)) << pos;
        y          = (a & ~field_mask) | ((b << pos) & field_mask);
    end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
    import bfu_pkg::*;
#(
    parameter int DW = DATA_W,
    localparam int PW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] pos_in,
    input  logic [DW-1:0] wid_in,
    output logic [DW-1:0] result,
    output logic          done
);
    bf_state_e     st_q, st_nxt;
    bf_op_e        op_sel;
    logic [PW-1:0] pos_m, wid_m;
    logic [DW-1:0] y_dext, y_ext, y_ins, y_sel;
    logic [DW-1:0] res_q;

    // R2, R3: only the low bits of the position and width operands count
    assign pos_m  = pos_in[PW-1:0];
    assign wid_m  = wid_in[PW-1:0];
    assign op_sel = bf_op_e'(op);

    bfu_funnel #(.DW(DW)) u_funnel (
        .hi(opa), .lo(opb), .sh(pos_m), .y(y_dext)
    );

    bfu_extract #(.DW(DW)) u_extract (
        .a(opa), .pos(pos_m), .wid(wid_m),
        .sign_ext(op_sel == OP_SEXT), .y(y_ext)
    );

    bfu_insert #(.DW(DW)) u_insert (
        .a(opa), .b(opb), .pos(pos_m), .wid(wid_m), .y(y_ins)
    );

    // R1: operation select
    always_comb begin
        unique case (op_sel)
            OP_DEXT: y_sel = y_dext;
            OP_SEXT,
            OP_UEXT: y_sel = y_ext;
            OP_INS:  y_sel = y_ins;
            default: y_sel = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    // Transitions: wait, launch, chain, retire
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   st_nxt = start ? ST_RESULT : ST_IDLE;
            ST_RESULT: st_nxt = start ? ST_RESULT : ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // Output process
    always_ff @(posedge clk) begin
        if (rst)        res_q <= '0;
        else if (start) res_q <= y_sel;
    end

    assign result = res_q;
    assign done   = (st_q == ST_RESULT);

    a_r11_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);
    a_r11_idle_clears_done: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done);
    a_r11_result_holds: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(result));
    a_r4_pos_zero: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd0 && pos_in[PW-1:0] == '0) |=> result == $past(opa));
    a_r6_zero_width_extract: assert property (@(posedge clk) disable iff (rst)
        (start && (op == 2'd1 || op == 2'd2) && wid_in[PW-1:0] == '0) |=> result == '0);
    a_r10_zero_width_insert: assert property (@(posedge clk) disable iff (rst)
        (start && op == 2'd3 && wid_in[PW-1:0] == '0) |=> result == $past(opa));
    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (result == '0 && !done));
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [31:0] opa = '0, opb = '0, pos_in = '0, wid_in = '0;
    logic [31:0] result;
    logic        done;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit started = 1'b0;
    bit finished = 1'b0;

    logic [31:0] exp_res = '0;
    logic        exp_done = 1'b0;
    string       cur_tag = "R12";
    string       exp_tag = "R12";

    always #5 clk = ~clk;

    bitfield_unit u_bitfield_unit (
        .clk(clk), .rst(rst), .start(start), .op(op),
        .opa(opa), .opb(opb), .pos_in(pos_in), .wid_in(wid_in),
        .result(result), .done(done)
    );

    function automatic logic [31:0] ref_calc(input int code, input logic [31:0] a,
                                             input logic [31:0] b, input logic [31:0] pv,
                                             input logic [31:0] wv);
        int p, w, n, s;
        logic [31:0] r;
        p = int'(pv & 32'd31);
        w = int'(wv & 32'd31);
        r = '0;
        n = 0;
        if (code == 0) begin
            for (int i = 0; i < 32; i++) begin
                s = i + 32 - p;
                r[i] = (s >= 32) ? a[s-32] : b[s];
            end
        end else if (code == 1 || code == 2) begin
            for (int i = 0; i < w; i++)
                if (p + i < 32) begin
                    r[i] = a[p+i];
                    n = i + 1;
                end
            if (code == 1 && n > 0 && r[n-1])
                for (int i = n; i < 32; i++) r[i] = 1'b1;
        end else begin
            r = a;
            for (int i = 0; i < w; i++)
                if (p + i < 32) r[p+i] = b[i];
        end
        return r;
    endfunction

    // Behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            exp_res  <= '0;
            exp_done <= 1'b0;
            exp_tag  <= "R12";
        end else begin
            exp_done <= start;
            if (start) exp_res <= ref_calc(int'(op), opa, opb, pos_in, wid_in);
            exp_tag <= start ? cur_tag : "R11";
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (started && !finished) begin
            n_cmp++;
            if (done !== exp_done) begin
                n_bad++;
                $display("FAIL %s/R11 done: actual %0b expected %0b", exp_tag, done, exp_done);
            end else if (result !== exp_res) begin
                n_bad++;
                $display("FAIL %s result: actual %08h expected %08h", exp_tag, result, exp_res);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !finished) begin
            finished = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic issue(input int code, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] p, input logic [31:0] w, input string tag);
        @(negedge clk);
        start = 1'b1; op = 2'(code); opa = a; opb = b; pos_in = p; wid_in = w;
        cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start = 1'b0;
            opa = $urandom; opb = $urandom; pos_in = $urandom; wid_in = $urandom;
        end
    endtask

    initial begin
        // R12: reset state observed for a few cycles
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle(2);
        // R4: funnel window, position 0 and a mid position
        issue(0, 32'h1234_5678, 32'h9abc_def0, 32'd0, 32'd0, "R4");
        issue(0, 32'h1234_5678, 32'h9abc_def0, 32'd8, 32'd0, "R4");
        issue(0, 32'h8000_0001, 32'hffff_ffff, 32'd31, 32'd0, "R4");
        // R5: same operand gives rotate
        issue(0, 32'hf00d_cafe, 32'hf00d_cafe, 32'd12, 32'd0, "R5");
        // R6 / R7: signed and unsigned extract
        issue(1, 32'h0000_0f80, 32'h0, 32'd4, 32'd5, "R6");
        issue(2, 32'h0000_0f80, 32'h0, 32'd4, 32'd5, "R7");
        issue(1, 32'hffff_ffff, 32'h0, 32'd3, 32'd0, "R6");
        issue(2, 32'hffff_ffff, 32'h0, 32'd3, 32'd0, "R7");
        // R8: field crossing bit 31
        issue(1, 32'hc000_0000, 32'h0, 32'd28, 32'd10, "R8");
        issue(2, 32'hc000_0000, 32'h0, 32'd28, 32'd10, "R8");
        issue(1, 32'h4000_0000, 32'h0, 32'd30, 32'd31, "R8");
        // R9 / R10: insert
        issue(3, 32'hffff_ffff, 32'h0000_0000, 32'd8, 32'd4, "R9");
        issue(3, 32'h0000_0000, 32'hffff_ffff, 32'd30, 32'd6, "R9");
        issue(3, 32'h1357_9bdf, 32'hffff_ffff, 32'd7, 32'd0, "R10");
        // R2 / R3: junk in upper bits of position and width
        issue(1, 32'h00ab_c000, 32'h0, 32'hdead_bee0 | 32'd12, 32'hffff_ffe0 | 32'd8, "R2");
        issue(3, 32'h0, 32'h0000_00ff, 32'h1234_5660 | 32'd4, 32'hcafe_ba80 | 32'd4, "R3");
        idle(3);
        // R1 / R11: random mix, back-to-back and with gaps
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] pp, ww;
            pp = $urandom;
            ww = $urandom;
            if (k % 7 == 0) pp[4:0] = 5'd0;
            if (k % 11 == 0) ww[4:0] = 5'd0;
            if (k % 5 == 0) pp[4:0] = 5'd31 - 5'($urandom_range(0, 3));
            issue(int'($urandom_range(0, 3)), $urandom, $urandom, pp, ww, "R1");
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(2);
        // R12: reset in mid-operation
        issue(3, 32'hffff_ffff, 32'h0, 32'd0, 32'd5, "R9");
        @(negedge clk);
        start = 1'b0; rst = 1'b1;
        cur_tag = "R12";
        idle(2);
        rst = 1'b0;
        idle(3);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule